// File: doc/BRIEF.md
# Coherent Sampling Strobe Generator

This block turns a fast reference clock into the sampling strobe for on-chip signal-integrity monitors. It divides the reference clock by a programmable value DIV, so one strobe falls every DIV reference cycles. A unit test period (UTP) holds N strobes, which is N*DIV reference cycles. Software or a test controller picks N, DIV and the signal-under-test period so that one UTP spans exactly M periods of the signal under test. Because M and N share no common factor, the N samples of a UTP land on N distinct phases of the signal, evenly spaced at one N-th of its period. The block also gives each strobe its index within the UTP, marks the start of every UTP, and drives a level flag that tells the monitor logic which stable logic level is being judged.

A small state machine controls the block. Its states are `ST_IDLE`, `ST_CHECK`, `ST_RUN` and `ST_FAULT`. The transitions are:
- `ST_IDLE` to `ST_CHECK`: this happens unconditionally in the first cycle after reset, and the settings are captured.
- `ST_CHECK` to `ST_RUN` or to `ST_FAULT`: when the greatest-common-divisor engine finishes, the captured settings are judged valid or invalid.
- `ST_RUN` to `ST_CHECK`: on the last cycle of a UTP, if the inputs differ from the active settings.
- `ST_FAULT` to `ST_CHECK`: whenever the inputs differ from the captured settings.

In `ST_RUN`, a UTP boundary with unchanged inputs stays in `ST_RUN`, and the next UTP follows without a gap.

Top module: `coh_sample_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, sample_stb, utp_start, level_hi and cfg_err are 0 and sample_idx is 0.
- R2: A setting is valid exactly when M >= 1, N >= 2, DIV >= 1 and gcd(M, N) = 1.
- R3: With an invalid setting, cfg_err is 1 and sample_stb, utp_start and level_hi stay 0. This holds until any of the three setting inputs changes.
- R4: With a valid setting, sample_stb is high for one reference cycle and then low for DIV-1 cycles. A UTP lasts N*DIV cycles and contains exactly N strobes.
- R5: sample_idx equals k during and after the k-th strobe of a UTP, counting from 0, up to the next strobe. It runs 0..N-1 and then wraps to 0.
- R6: utp_start is 1 only in the cycle of the strobe with index 0, for one cycle.
- R7: level_hi is 1 while 2*sample_idx < N and 0 otherwise, so with N=8 indices 0..3 are high and 4..7 are low. It changes only in strobe cycles, and it repeats once per UTP.
- R8: Setting inputs that change inside a UTP have no effect until the last cycle of that UTP. If the inputs at that cycle equal the active setting, the next cycle begins a new UTP with a strobe at index 0.
- R9: If the inputs at the UTP boundary differ from the active setting, the check runs first. During the check, sample_stb, utp_start and level_hi are 0. After it, either a UTP of the new setting starts or cfg_err is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_m | input | MW (8) | Signal periods per UTP (M) |
| cfg_n | input | NW (8) | Samples per UTP (N) |
| cfg_div | input | DW (8) | Reference cycles between strobes |
| sample_stb | output | 1 | One-cycle sample strobe |
| sample_idx | output | NW (8) | Index of the current sample in the UTP |
| utp_start | output | 1 | Marks the strobe that opens a UTP |
| level_hi | output | 1 | 1 while the high level is under test, 0 for the low level |
| cfg_err | output | 1 | Captured setting is not coherent or out of range |

## Verification
A divider count off by one shows within a single UTP as a strobe at the wrong cycle. A wrong index wrap shows as an index skipped or repeated at the next strobe. A wrong boundary decision shows as a missing or late utp_start in the cycle after the UTP's last cycle. Errors in the coprime test show as soon as the check ends, as a cfg_err value that disagrees with an arithmetic gcd. Because settings are changed halfway through a UTP, a block that applies them early corrupts the strobes that remain in that same UTP.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } coh_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/coh_gcd_engine.sv
module coh_gcd_engine #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [GW-1:0] a_in,
    input  logic [GW-1:0] b_in,
    output logic          done,
    output logic [GW-1:0] result
);
    logic [GW-1:0] a_q, b_q;
    logic          busy_q;

    // Subtractive Euclid: one subtraction per cycle until an operand is zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
            result <= '0;
        end else if (start) begin
            a_q    <= a_in;
            b_q    <= b_in;
            busy_q <= 1'b1;
            done   <= 1'b0;
        end else if (busy_q) begin
            if (a_q == '0 || b_q == '0) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
                result <= a_q | b_q;
            end else if (a_q >= b_q) begin
                a_q  <= a_q - b_q;
                done <= 1'b0;
            end else begin
                b_q  <= b_q - a_q;
                done <= 1'b0;
            end
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/coh_tick_counter.sv
module coh_tick_counter #(
    parameter int DW = 8,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          enable,
    input  logic [DW-1:0] div_val,
    input  logic [NW-1:0] n_val,
    output logic          tick,
    output logic [NW-1:0] idx,
    output logic          last
);
    logic [DW-1:0] div_cnt_q;
    logic [NW-1:0] idx_q;
    logic          div_wrap;
    logic          idx_wrap;

    assign div_wrap = (div_cnt_q == div_val - DW'(1));
    assign idx_wrap = (idx_q == n_val - NW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            div_cnt_q <= '0;
            idx_q     <= '0;
        end else if (enable) begin
            if (div_wrap) begin
                div_cnt_q <= '0;
                idx_q     <= idx_wrap ? '0 : idx_q + NW'(1);
            end else begin
                div_cnt_q <= div_cnt_q + DW'(1);
            end
        end
    end

    assign tick = (div_cnt_q == '0);
    assign idx  = idx_q;
    assign last = div_wrap && idx_wrap;
endmodule

// File: rtl/coh_ctrl_fsm.sv
module coh_ctrl_fsm
    import coh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_same,
    input  logic gcd_done,
    input  logic cfg_ok,
    input  logic utp_last,
    output logic cap_en,
    output logic cnt_clear,
    output logic cnt_en,
    output logic run_on,
    output logic fault_on
);
    coh_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_CHECK;
            ST_CHECK: if (gcd_done) state_d = cfg_ok ? ST_RUN : ST_FAULT;
            ST_RUN:   if (utp_last && !cfg_same) state_d = ST_CHECK;
            ST_FAULT: if (!cfg_same) state_d = ST_CHECK;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_en    = 1'b0;
        cnt_clear = 1'b0;
        cnt_en    = 1'b0;
        run_on    = 1'b0;
        fault_on  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cap_en    = 1'b1;
                cnt_clear = 1'b1;
            end
            ST_CHECK: cnt_clear = 1'b1;
            ST_RUN: begin
                run_on = 1'b1;
                cnt_en = 1'b1;
                cap_en = utp_last && !cfg_same;
            end
            ST_FAULT: begin
                fault_on  = 1'b1;
                cnt_clear = 1'b1;
                cap_en    = !cfg_same;
            end
            default: cnt_clear = 1'b1;
        endcase
    end
endmodule

// File: rtl/coh_sample_gen.sv
module coh_sample_gen
    import coh_pkg::*;
#(
    parameter int MW = 8,
    parameter int NW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] cfg_m,
    input  logic [NW-1:0] cfg_n,
    input  logic [DW-1:0] cfg_div,
    output logic          sample_stb,
    output logic [NW-1:0] sample_idx,
    output logic          utp_start,
    output logic          level_hi,
    output logic          cfg_err
);
    localparam int GW = int'(max_u(MW, NW));

    logic [MW-1:0] m_act;
    logic [NW-1:0] n_act;
    logic [DW-1:0] d_act;
    logic          cap_en, cnt_clear, cnt_en, run_on, fault_on;
    logic          gcd_done;
    logic [GW-1:0] gcd_res;
    logic          cfg_ok, cfg_same;
    logic          tick, utp_last;
    logic [NW-1:0] idx;

    // Active settings, reloaded only when the controller grants a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_act <= '0;
            n_act <= '0;
            d_act <= '0;
        end else if (cap_en) begin
            m_act <= cfg_m;
            n_act <= cfg_n;
            d_act <= cfg_div;
        end
    end

    assign cfg_same = (cfg_m == m_act) && (cfg_n == n_act) && (cfg_div == d_act);
    assign cfg_ok   = (m_act != '0) && (n_act >= NW'(2)) && (d_act != '0)
                   && (gcd_res == GW'(1));

    coh_gcd_engine #(.GW(GW)) gcd_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cap_en),
        .a_in   (GW'(cfg_m)),
        .b_in   (GW'(cfg_n)),
        .done   (gcd_done),
        .result (gcd_res)
    );

    coh_tick_counter #(.DW(DW), .NW(NW)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .enable  (cnt_en),
        .div_val (d_act),
        .n_val   (n_act),
        .tick    (tick),
        .idx     (idx),
        .last    (utp_last)
    );

    coh_ctrl_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_same  (cfg_same),
        .gcd_done  (gcd_done),
        .cfg_ok    (cfg_ok),
        .utp_last  (utp_last),
        .cap_en    (cap_en),
        .cnt_clear (cnt_clear),
        .cnt_en    (cnt_en),
        .run_on    (run_on),
        .fault_on  (fault_on)
    );

    assign sample_stb = run_on && tick;
    assign sample_idx = run_on ? idx : '0;
    assign utp_start  = sample_stb && (idx == '0);
    assign level_hi   = run_on && ({idx, 1'b0} < {1'b0, n_act});
    assign cfg_err    = fault_on;
endmodule

// File: rtl/coh_sample_gen_chk.sv
module coh_sample_gen_chk #(
    parameter int NW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_stb,
    input logic [NW-1:0] sample_idx,
    input logic          utp_start,
    input logic          level_hi,
    input logic          cfg_err
);
    logic [NW-1:0] last_idx;
    logic          seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_idx <= '0;
            seen     <= 1'b0;
        end else if (sample_stb) begin
            last_idx <= sample_idx;
            seen     <= 1'b1;
        end
    end

    // R3
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!sample_stb && !utp_start && !level_hi));

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && sample_idx != '0) |-> (seen && sample_idx == last_idx + NW'(1)));

    // R6
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        utp_start |=> !utp_start);

    // R6
    start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        utp_start |-> (sample_stb && sample_idx == '0));

    // R7
    level_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        utp_start |-> level_hi);

    // R7
    level_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(level_hi) || !level_hi);
endmodule

bind coh_sample_gen coh_sample_gen_chk #(.NW(NW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .sample_idx (sample_idx),
    .utp_start  (utp_start),
    .level_hi   (level_hi),
    .cfg_err    (cfg_err)
);

// File: tb/coh_sample_gen_tb.sv
`timescale 1ns/1ps
module coh_sample_gen_tb_top;
    localparam int NCFG = 85;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_m = 8'd0, cfg_n = 8'd0, cfg_div = 8'd0;
    logic       sample_stb, utp_start, level_hi, cfg_err;
    logic [7:0] sample_idx;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    coh_sample_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_div(cfg_div),
        .sample_stb(sample_stb), .sample_idx(sample_idx), .utp_start(utp_start),
        .level_hi(level_hi), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int gcd(input int a, input int b);
        int x = a;
        int y = b;
        while (y != 0) begin
            int t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic void cfg_of(input int i, output int m, output int n, output int d);
        if (i >= NCFG) begin m = 1; n = 2; d = 1; end
        else if (i == NCFG - 1) begin m = 3; n = 4; d = 0; end
        else begin
            m = 1 + i / 21;
            n = (i / 3) % 7;
            d = 1 + i % 3;
        end
    endfunction

    task automatic apply(input int m, input int n, input int d);
        cfg_m = 8'(m); cfg_n = 8'(n); cfg_div = 8'(d);
    endtask

    // Checks one UTP cycle by cycle; changes the inputs after cycle chg_at.
    task automatic check_utp(input int n, input int d, input int chg_at,
                             input int nm, input int nn, input int nd);
        for (int t = 0; t < n * d; t++) begin
            check("R4 strobe", int'(sample_stb), int'(t % d == 0));
            check("R5 index", int'(sample_idx), t / d);
            check("R6 utp_start", int'(utp_start), int'(t == 0));
            check("R7 level", int'(level_hi), int'(2 * (t / d) < n));
            check("R8 no error while running", int'(cfg_err), 0);
            if (t == chg_at) apply(nm, nn, nd);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #400000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int m, n, d, nm, nn, nd;
        cfg_of(0, m, n, d);
        apply(m, n, d);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 stb in reset", int'(sample_stb), 0);
        check("R1 idx in reset", int'(sample_idx), 0);
        check("R1 start in reset", int'(utp_start), 0);
        check("R1 level in reset", int'(level_hi), 0);
        check("R1 err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stb after reset", int'(sample_stb), 0);
        check("R1 err after reset", int'(cfg_err), 0);

        for (int i = 0; i < NCFG; i++) begin
            bit exp_err;
            int waited;
            cfg_of(i, m, n, d);
            cfg_of(i + 1, nm, nn, nd);
            exp_err = (m == 0) || (n < 2) || (d == 0) || (gcd(m, n) != 1);
            waited = 0;
            // R9: quiet while the new setting is checked
            while (!utp_start && !cfg_err && waited < 600) begin
                check("R9 quiet during check", int'(sample_stb) + int'(level_hi), 0);
                @(negedge clk);
                waited++;
            end
            if (waited >= 600) check("R9 check finished", 0, 1);
            // R2 validity decision
            check("R2 error flag", int'(cfg_err), int'(exp_err));
            if (cfg_err) begin
                for (int k = 0; k < 4; k++) begin
                    check("R3 quiet in error", int'(sample_stb) + int'(utp_start) + int'(level_hi), 0);
                    check("R3 error held", int'(cfg_err), 1);
                    @(negedge clk);
                end
                apply(nm, nn, nd);
                @(negedge clk);
            end else if (utp_start) begin
                // first UTP untouched, second UTP is seamless (R8), change mid-way
                check_utp(n, d, -1, m, n, d);
                check("R8 seamless next UTP", int'(utp_start), 1);
                check_utp(n, d, (n * d) / 2, nm, nn, nd);
            end
        end
        finish_run();
    end
endmodule